// File: doc/BRIEF.md
# Delayed Block-Write Bus Sequencer

This block is the write side of a bus master on a shared address/data bus. Once a write is accepted it drives a single address cycle. It then leaves the bus idle for a programmed number of cycles, which gives SDRAM-style memories time between the command and the data. After that it drives the write data. Setting the gap to zero gives the classic back-to-back timing, where data follows the address directly.

Block writes move a whole cache line. That is four 64-bit beats on a wide bus or eight 32-bit beats on a narrow bus. A rate code spaces these beats with idle cycles so that a slow memory can keep up. Single writes ignore the rate code. On a narrow bus, a single write wider than four bytes is split into two consecutive beats. An active-low strobe marks every cycle in which the master owns the bus.

Everything that shapes a transaction is captured in the cycle the request is accepted. A controller may therefore set up the next request while the current one is still running.

Top module: `wbs_write_seq`

## Requirements
- R1: After reset, `busy` is 0, `valid_n` is 1, `addr_phase` is 0 and `bus_ad` is all zeros.
- R2: A request is accepted at a clock edge only if, at that edge, `busy` is 0, `req_start` is 1 and `wr_rdy` is 1. In the cycle after acceptance the bus shows the address cycle: `addr_phase`=1, `valid_n`=0 and `bus_ad` = `req_addr` zero-extended. Requests made while `wr_rdy` is 0 or while `busy` is 1 are ignored.
- R3: After the address cycle there are exactly `wr_delay` (0..7) idle cycles before the first data beat. A delay of 0 puts the first data beat in the cycle right after the address cycle. This holds for block writes and single writes alike.
- R4: A block write with `bus_narrow`=0 drives four beats, `req_data[64k+63:64k]` for k = 0..3 in rising order. With `bus_narrow`=1 it drives eight beats, `req_data[32k+31:32k]` on `bus_ad[31:0]` for k = 0..7 in rising order, with `bus_ad[63:32]` held at zero.
- R5: For block writes, the `rate_code` splits the beats into groups of G back-to-back beats with I idle cycles between groups. The (G, I) values are: code 0 (1,0), code 1 (2,1), code 2 (2,2), code 3 (1,1), code 4 (2,3), code 5 (2,4), code 6 (1,2), code 7 (2,6), code 8 (1,3). On a narrow bus the same grouping simply runs over eight beats.
- R6: Rate codes 9 to 15 behave exactly like code 0.
- R7: A single write ignores `rate_code`. With `bus_narrow`=0 it drives one beat, `req_data[63:0]`. With `bus_narrow`=1 and `req_big`=0 it drives one beat, `req_data[31:0]`. With `bus_narrow`=1 and `req_big`=1 it drives two back-to-back beats: `req_data[31:0]` first, then `req_data[63:32]`.
- R8: `valid_n` is 0 only in the address cycle and in data cycles. In every other cycle `bus_ad` is zero. `addr_phase` lasts exactly one cycle. `busy` is 1 from the address cycle through the last data beat and 0 in the next cycle: idle cycles that would trail the last beat are not spent.
- R9: `req_addr`, `req_data`, `req_block`, `req_big`, `bus_narrow`, `wr_delay` and `rate_code` are sampled only at acceptance. Changing them during a transaction does not affect that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_start | input | 1 | Request to start a write |
| req_block | input | 1 | 1 = cache-line block write, 0 = single write |
| req_big | input | 1 | Single write is wider than four bytes |
| req_addr | input | ADDR_W (36) | Write address |
| req_data | input | 4*BUS_W (256) | Write data, beat 0 in the low bits |
| wr_rdy | input | 1 | Target can take a write |
| bus_narrow | input | 1 | 1 = 32-bit bus, 0 = 64-bit bus |
| wr_delay | input | 3 | Idle cycles between address and first data |
| rate_code | input | 4 | Block-write beat spacing code |
| bus_ad | output | BUS_W (64) | Multiplexed address/data bus |
| valid_n | output | 1 | Active-low strobe: master drives the bus |
| addr_phase | output | 1 | Current bus cycle carries the address |
| busy | output | 1 | A transaction is in progress |

## Verification
The bench predicts the full bus trace for each transaction, cycle by cycle. It tries every rate code at both bus widths, delays of 0 and 7, and reserved codes. Getting a group boundary wrong would shift beats or add idles, and the trace comparison flags either one. Mishandling a delay of 0 would add a bogus idle cycle or swallow a data beat. It also checks single writes with a rate code attached: a design that applied the pattern there would insert idles between the two halves of a split narrow write. Finally, it changes the inputs mid-transaction and re-pulses the request while busy. A design that reads live inputs or restarts would corrupt the running trace.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_GAP,
        ST_DATA,
        ST_SKIP
    } wbs_state_e;

    // Beat grouping of a block write: beats per burst group and idle cycles
    // between groups.
    typedef struct packed {
        logic [1:0] grp;
        logic [2:0] idle;
    } wbs_rate_t;

    function automatic wbs_rate_t rate_lookup(input logic [3:0] code);
        wbs_rate_t r;
        case (code)
            4'd1:    r = '{grp: 2'd2, idle: 3'd1};
            4'd2:    r = '{grp: 2'd2, idle: 3'd2};
            4'd3:    r = '{grp: 2'd1, idle: 3'd1};
            4'd4:    r = '{grp: 2'd2, idle: 3'd3};
            4'd5:    r = '{grp: 2'd2, idle: 3'd4};
            4'd6:    r = '{grp: 2'd1, idle: 3'd2};
            4'd7:    r = '{grp: 2'd2, idle: 3'd6};
            4'd8:    r = '{grp: 2'd1, idle: 3'd3};
            default: r = '{grp: 2'd1, idle: 3'd0}; // code 0 and reserved
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wbs_rate_decode.sv
module wbs_rate_decode
    import wbs_pkg::*;
(
    input  logic [3:0] code,
    input  logic       block,
    output wbs_rate_t  rate
);
    // Single writes never use spacing.
    always_comb begin
        if (block) rate = rate_lookup(code);
        else       rate = '{grp: 2'd1, idle: 3'd0};
    end
endmodule

// File: rtl/wbs_beat_mux.sv
module wbs_beat_mux #(
    parameter int BUS_W     = 64,
    parameter int BLK_BEATS = 4
) (
    input  logic [BUS_W*BLK_BEATS-1:0]       data,
    input  logic                             narrow,
    input  logic [$clog2(2*BLK_BEATS)-1:0]   idx,
    output logic [BUS_W-1:0]                 beat
);
    localparam int HALF_W = BUS_W / 2;
    localparam int NBEATS = 2 * BLK_BEATS;
    localparam int IDX_W  = $clog2(NBEATS);

    logic [BUS_W-1:0]  wide_w [BLK_BEATS];
    logic [HALF_W-1:0] nar_w  [NBEATS];

    for (genvar g = 0; g < BLK_BEATS; g++) begin : g_wide
        assign wide_w[g] = data[g*BUS_W +: BUS_W];
    end
    for (genvar g = 0; g < NBEATS; g++) begin : g_nar
        assign nar_w[g] = data[g*HALF_W +: HALF_W];
    end

    always_comb begin
        if (narrow) beat = {{HALF_W{1'b0}}, nar_w[idx]};
        else        beat = wide_w[idx[IDX_W-2:0]];
    end
endmodule

// File: rtl/wbs_seq_fsm.sv
module wbs_seq_fsm
    import wbs_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [2:0]       delay_in,
    input  wbs_rate_t        rate_in,
    input  logic [IDX_W-1:0] last_in,
    output wbs_state_e       state,
    output logic [IDX_W-1:0] beat_idx
);
    logic [2:0]       cnt;
    logic [1:0]       pos;
    logic [2:0]       delay_q;
    wbs_rate_t        rate_q;
    logic [IDX_W-1:0] last_q;
    logic             grp_end;

    assign grp_end = ({1'b0, pos} + 3'd1) == {1'b0, rate_q.grp};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            pos      <= '0;
            beat_idx <= '0;
            delay_q  <= '0;
            rate_q   <= '{grp: 2'd1, idle: 3'd0};
            last_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        delay_q  <= delay_in;
                        rate_q   <= rate_in;
                        last_q   <= last_in;
                        beat_idx <= '0;
                        pos      <= '0;
                        state    <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (delay_q == 3'd0) begin
                        state <= ST_DATA;
                    end else begin
                        cnt   <= delay_q;
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (cnt == 3'd1) state <= ST_DATA;
                    else             cnt   <= cnt - 3'd1;
                end
                ST_DATA: begin
                    if (beat_idx == last_q) begin
                        state <= ST_IDLE;
                    end else begin
                        beat_idx <= beat_idx + 1'b1;
                        if (grp_end) begin
                            pos <= '0;
                            if (rate_q.idle != 3'd0) begin
                                cnt   <= rate_q.idle;
                                state <= ST_SKIP;
                            end
                        end else begin
                            pos <= pos + 2'd1;
                        end
                    end
                end
                ST_SKIP: begin
                    if (cnt == 3'd1) state <= ST_DATA;
                    else             cnt   <= cnt - 3'd1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wbs_write_seq.sv
module wbs_write_seq
    import wbs_pkg::*;
#(
    parameter int ADDR_W    = 36,
    parameter int BUS_W     = 64,
    parameter int BLK_BEATS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_start,
    input  logic                       req_block,
    input  logic                       req_big,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [BUS_W*BLK_BEATS-1:0] req_data,
    input  logic                       wr_rdy,
    input  logic                       bus_narrow,
    input  logic [2:0]                 wr_delay,
    input  logic [3:0]                 rate_code,
    output logic [BUS_W-1:0]           bus_ad,
    output logic                       valid_n,
    output logic                       addr_phase,
    output logic                       busy
);
    localparam int DATA_W = BUS_W * BLK_BEATS;
    localparam int NBEATS = 2 * BLK_BEATS;
    localparam int IDX_W  = $clog2(NBEATS);

    wbs_state_e       state;
    logic [IDX_W-1:0] beat_idx;
    logic [IDX_W-1:0] last_in;
    wbs_rate_t        rate;
    logic             accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              narrow_q;
    logic [BUS_W-1:0]  beat;

    assign accept = (state == ST_IDLE) && req_start && wr_rdy;

    always_comb begin
        if (req_block)
            last_in = bus_narrow ? IDX_W'(NBEATS - 1) : IDX_W'(BLK_BEATS - 1);
        else
            last_in = (bus_narrow && req_big) ? IDX_W'(1) : IDX_W'(0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            data_q   <= '0;
            narrow_q <= 1'b0;
        end else if (accept) begin
            addr_q   <= req_addr;
            data_q   <= req_data;
            narrow_q <= bus_narrow;
        end
    end

    wbs_rate_decode u_rate (
        .code  (rate_code),
        .block (req_block),
        .rate  (rate)
    );

    wbs_seq_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .delay_in (wr_delay),
        .rate_in  (rate),
        .last_in  (last_in),
        .state    (state),
        .beat_idx (beat_idx)
    );

    wbs_beat_mux #(.BUS_W(BUS_W), .BLK_BEATS(BLK_BEATS)) u_mux (
        .data   (data_q),
        .narrow (narrow_q),
        .idx    (beat_idx),
        .beat   (beat)
    );

    always_comb begin
        case (state)
            ST_ADDR: bus_ad = {{(BUS_W-ADDR_W){1'b0}}, addr_q};
            ST_DATA: bus_ad = beat;
            default: bus_ad = '0;
        endcase
    end

    assign addr_phase = (state == ST_ADDR);
    assign valid_n    = !((state == ST_ADDR) || (state == ST_DATA));
    assign busy       = (state != ST_IDLE);
endmodule

// File: rtl/wbs_write_seq_chk.sv
module wbs_write_seq_chk #(
    parameter int BUS_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             req_start,
    input logic             wr_rdy,
    input logic [BUS_W-1:0] bus_ad,
    input logic             valid_n,
    input logic             addr_phase,
    input logic             busy
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && valid_n && !addr_phase));

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_start && wr_rdy) |=> (addr_phase && !valid_n));

    assert_hold_off_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(req_start && wr_rdy)) |=> !busy);

    assert_strobe_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
        !valid_n |-> busy);

    assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (rst)
        valid_n |-> (bus_ad == '0));

    assert_addr_single_R8: assert property (@(posedge clk) disable iff (rst)
        addr_phase |=> (!addr_phase && busy));
endmodule

bind wbs_write_seq wbs_write_seq_chk #(.BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_start  (req_start),
    .wr_rdy     (wr_rdy),
    .bus_ad     (bus_ad),
    .valid_n    (valid_n),
    .addr_phase (addr_phase),
    .busy       (busy)
);

// File: tb/test_wbs_write_seq.sv
`timescale 1ns/1ps
module test_wbs_write_seq;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_start = 1'b0;
    logic         req_block = 1'b0;
    logic         req_big = 1'b0;
    logic [35:0]  req_addr = '0;
    logic [255:0] req_data = '0;
    logic         wr_rdy = 1'b1;
    logic         bus_narrow = 1'b0;
    logic [2:0]   wr_delay = '0;
    logic [3:0]   rate_code = '0;
    logic [63:0]  bus_ad;
    logic         valid_n;
    logic         addr_phase;
    logic         busy;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1 reset";
    logic [64:0] exp_q[$];

    always #2.5 clk = ~clk;

    wbs_write_seq i_wbs_write_seq (
        .clk(clk), .rst(rst), .req_start(req_start), .req_block(req_block),
        .req_big(req_big), .req_addr(req_addr), .req_data(req_data),
        .wr_rdy(wr_rdy), .bus_narrow(bus_narrow), .wr_delay(wr_delay),
        .rate_code(rate_code), .bus_ad(bus_ad), .valid_n(valid_n),
        .addr_phase(addr_phase), .busy(busy)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog: run hung (%s) actual=timeout expected=completion", cur_tag);
        finish_run();
    end

    // Spacing table per R5/R6.
    function automatic void spacing(input logic [3:0] code, output int g, output int i);
        case (code)
            1: begin g = 2; i = 1; end
            2: begin g = 2; i = 2; end
            3: begin g = 1; i = 1; end
            4: begin g = 2; i = 3; end
            5: begin g = 2; i = 4; end
            6: begin g = 1; i = 2; end
            7: begin g = 2; i = 6; end
            8: begin g = 1; i = 3; end
            default: begin g = 1; i = 0; end
        endcase
    endfunction

    // Scoreboard monitor: every busy cycle is compared with the prediction.
    always @(negedge clk) begin
        if (!rst && busy) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: extra bus cycle actual=%b/%h expected=none",
                         cur_tag, valid_n, bus_ad);
            end else begin
                logic [64:0] e;
                e = exp_q.pop_front();
                if ({valid_n, bus_ad} !== e) begin
                    errors++;
                    $display("FAIL %s: actual valid_n=%b bus=%h expected valid_n=%b bus=%h",
                             cur_tag, valid_n, bus_ad, e[64], e[63:0]);
                end
            end
        end
    end

    function automatic logic [255:0] mkdata(input logic [31:0] base);
        logic [255:0] d;
        for (int k = 0; k < 8; k++) d[32*k +: 32] = base + 32'h1111_1111 * k;
        return d;
    endfunction

    task automatic run_write(input string tag, input logic [35:0] a, input logic [255:0] d,
                             input bit blk, input bit big, input bit nar,
                             input logic [2:0] dly, input logic [3:0] code, input bit disturb);
        int g, i, nb;
        cur_tag = tag;
        exp_q.push_back({1'b0, 28'h0, a});
        for (int k = 0; k < dly; k++) exp_q.push_back(65'h1_0000_0000_0000_0000);
        if (blk) begin
            spacing(code, g, i);
            nb = nar ? 8 : 4;
        end else begin
            g = 1; i = 0;
            nb = (nar && big) ? 2 : 1;
        end
        for (int b = 0; b < nb; b++) begin
            if (nar) exp_q.push_back({1'b0, 32'h0, d[32*b +: 32]});
            else     exp_q.push_back({1'b0, d[64*b +: 64]});
            if (b != nb - 1 && ((b + 1) % g) == 0)
                for (int k = 0; k < i; k++) exp_q.push_back(65'h1_0000_0000_0000_0000);
        end
        req_addr = a; req_data = d; req_block = blk; req_big = big;
        bus_narrow = nar; wr_delay = dly; rate_code = code; req_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_start = 1'b0;
        if (disturb) begin
            // R9/R2: new inputs and a repeated request while busy are ignored.
            req_addr = ~a; req_data = ~d; req_block = ~blk; req_big = ~big;
            bus_narrow = ~nar; wr_delay = ~dly; rate_code = 4'd7; req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
        end
        do @(negedge clk); while (busy);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: busy ended early, actual remaining=%0d expected=0",
                     tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (busy !== 1'b0 || valid_n !== 1'b1 || addr_phase !== 1'b0 || bus_ad !== '0) begin
            errors++;
            $display("FAIL R1: actual busy=%b valid_n=%b addr=%b bus=%h expected 0/1/0/0",
                     busy, valid_n, addr_phase, bus_ad);
        end

        // R2: no start without write-ready.
        wr_rdy = 1'b0; req_start = 1'b1; req_addr = 36'h123;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            checks++;
            if (busy !== 1'b0 || valid_n !== 1'b1) begin
                errors++;
                $display("FAIL R2 wr_rdy low: actual busy=%b valid_n=%b expected 0/1", busy, valid_n);
            end
        end
        req_start = 1'b0; wr_rdy = 1'b1;
        @(negedge clk);

        run_write("R3 R7 single64 delay0",       36'hA_0000_0010, mkdata(32'h0101_0000), 0, 1, 0, 3'd0, 4'd0, 0);
        run_write("R3 R7 single64 delay5 code8", 36'hA_0000_0020, mkdata(32'h0202_0000), 0, 1, 0, 3'd5, 4'd8, 0);
        run_write("R7 single32 small",           36'h0_0000_0030, mkdata(32'h0303_0000), 0, 0, 1, 3'd2, 4'd3, 0);
        run_write("R7 single32 big split code7", 36'h0_0000_0040, mkdata(32'h0404_0000), 0, 1, 1, 3'd2, 4'd7, 0);

        for (int c = 0; c <= 8; c++)
            run_write($sformatf("R4 R5 block64 code%0d", c), 36'h8_0000_0000 + 36'(c * 64),
                      mkdata(32'h1000_0000 + 32'(c)), 1, 0, 0, 3'(c % 8), 4'(c), 0);
        for (int c = 0; c <= 8; c++)
            run_write($sformatf("R4 R5 block32 code%0d", c), 36'h0_4000_0000 + 36'(c * 64),
                      mkdata(32'h2000_0000 + 32'(c)), 1, 0, 1, 3'(7 - (c % 8)), 4'(c), 0);

        run_write("R6 reserved code9 block64",  36'h1_0000_0000, mkdata(32'h3000_0000), 1, 0, 0, 3'd1, 4'd9, 0);
        run_write("R6 reserved code15 block32", 36'h1_0000_0100, mkdata(32'h3100_0000), 1, 0, 1, 3'd0, 4'd15, 0);

        run_write("R9 R2 disturb block32 code4", 36'h2_0000_0000, mkdata(32'h4000_0000), 1, 0, 1, 3'd3, 4'd4, 1);
        run_write("R9 R2 disturb single64",      36'h2_0000_0040, mkdata(32'h5000_0000), 0, 0, 0, 3'd0, 4'd2, 1);
        run_write("R8 back-to-back block64 code1", 36'h2_0000_0080, mkdata(32'h6000_0000), 1, 0, 0, 3'd0, 4'd1, 0);

        @(negedge clk);
        checks++;
        if (busy !== 1'b0 || valid_n !== 1'b1) begin
            errors++;
            $display("FAIL R8 final idle: actual busy=%b valid_n=%b expected 0/1", busy, valid_n);
        end
        finish_run();
    end
endmodule